// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Divider Bank

This block derives several output clocks from one fast source clock. Each output has its own divider, and the divider counts source cycles. A 3-bit select input picks one of eight preset ratio sets. Each set holds one ratio per output. The whole preset table is a single parameter vector.

A new select value first passes a two-flop synchronizer. It then waits as a pending value and is loaded into a divider only when that divider finishes a period. A period always finishes with the output low, so a ratio change never produces a runt pulse or a shortened phase.

One shared control pin has two uses, picked by a static mode input. In power-down mode, driving the pin low stops every output and restores the default ratio set. In output-enable mode, the pin gates only those outputs whose mask bit is set. An enable or disable also takes effect only at a period boundary.

Top module: `glitchless_div_bank`

## Requirements
- R1: While `rst_n` is low every output is low. On the first source edge after release, each output starts a period with its output high, using the entry at index DEFAULT_SEL (0).
- R2: The code for select `s` and output `c` sits at bits `[(s*NUM_OUT+c)*8 +: 8]` of SEL_TBL. Code `k` means a ratio of `k+1`, except that code 0 is treated as ratio 2. Ratios therefore run from 2 to 256.
- R3: With ratio R, each period is high for ceil(R/2) source cycles and then low for floor(R/2) source cycles.
- R4: The select input is synchronized through two flops and applied only at a period boundary. The rule for when it lands:
  - If the select changes in the first cycle of a period of ratio 4 or more, the current period keeps the old ratio.
  - The next period uses the new ratio.
- R5: Around a ratio change, no high or low phase is shorter than the phase it belongs to.
  - A change made partway through a high phase lets that high phase and its low phase finish at the old ratio.
  - The output rises only at a period start.
- R6: In output-enable mode (`mode_oe`=1), an output whose `oe_mask` bit is 1 is held low while `ctl_pin` is low. An output whose mask bit is 0 ignores `ctl_pin`.
- R7: Enable changes take effect only at a period boundary. A disable that arrives during a high phase lets that high phase run to full length. A re-enabled output starts with a full high phase.
- R8: In power-down mode (`mode_oe`=0), `ctl_pin` low drives all outputs low on the next source edge, whatever `oe_mask` holds.
- R9: When power-down is released, the first period of each output uses the default entry. The pending select is applied from the second period on.
- R10: The output is low in the last source cycle of every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsel | input | SEL_W | Ratio set select (asynchronous) |
| ctl_pin | input | 1 | Shared power-down / output-enable pin |
| mode_oe | input | 1 | 1: `ctl_pin` is an output enable; 0: `ctl_pin` is an active-low power-down |
| oe_mask | input | NUM_OUT | Per-output sensitivity to the enable pin |
| clk_out | output | NUM_OUT | Divided output clocks |

## Verification
Each output is a registered flop, so any change made at a period start shows up one source edge later.

- A power-down is visible at the first sample after the edge that sees `ctl_pin` low.
- A select change needs two edges for the synchronizer. It then takes effect at the edge that follows the period's last cycle.
- An enable change follows the same period-boundary timing.

The bench drives and samples on the falling edge. It locates a rising output, then counts high and low samples run by run. Each run length is compared with the old or the new ratio, depending on where the change fell relative to the period start. For latency cases it checks a fixed number of samples after the stimulus.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;

  // index of the final cycle of a period; code 0 is treated as ratio 2
  function automatic code_t last_idx(code_t c);
    return (c == '0) ? code_t'(1) : c;
  endfunction

  // number of high cycles: ceil(ratio/2)
  function automatic code_t high_len(code_t c);
    return (last_idx(c) >> 1) + code_t'(1);
  endfunction
endpackage

// File: rtl/sel_sync.sv
module sel_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/div_channel.sv
module div_channel
  import clkdiv_pkg::*;
#(
  parameter code_t DFLT_CODE = code_t'(1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pd,
  input  code_t pend_code,
  input  logic  en_req,
  output logic  clk_o,
  output logic  prd_end,
  output code_t code_act,
  output logic  en_act,
  output logic  armed
);
  code_t cnt_q, code_q;
  logic  en_q, out_q, armed_q;
  code_t cnt_nxt;

  assign cnt_nxt = cnt_q + code_t'(1);
  assign prd_end = armed_q && (cnt_q == last_idx(code_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      code_q  <= DFLT_CODE;
      en_q    <= 1'b0;
      out_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (pd) begin
      cnt_q   <= '0;
      code_q  <= DFLT_CODE;
      en_q    <= 1'b0;
      out_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      en_q    <= en_req;
      out_q   <= en_req;
    end else if (prd_end) begin
      cnt_q   <= '0;
      code_q  <= pend_code;
      en_q    <= en_req;
      out_q   <= en_req;
    end else begin
      cnt_q   <= cnt_nxt;
      out_q   <= en_q & (cnt_nxt < high_len(code_q));
    end
  end

  assign clk_o    = out_q;
  assign code_act = code_q;
  assign en_act   = en_q;
  assign armed    = armed_q;
endmodule

// File: rtl/glitchless_div_bank.sv
module glitchless_div_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT     = 3,
  parameter int SEL_W       = 3,
  parameter int DEFAULT_SEL = 0,
  parameter logic [CODE_W*NUM_OUT*(2**SEL_W)-1:0] SEL_TBL = {
    8'd10, 8'd0,  8'd5,
    8'd99, 8'd9,  8'd6,
    8'd3,  8'd5,  8'd255,
    8'd11, 8'd2,  8'd7,
    8'd2,  8'd15, 8'd4,
    8'd1,  8'd8,  8'd3,
    8'd4,  8'd1,  8'd2,
    8'd5,  8'd3,  8'd1 }
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   fsel,
  input  logic               ctl_pin,
  input  logic               mode_oe,
  input  logic [NUM_OUT-1:0] oe_mask,
  output logic [NUM_OUT-1:0] clk_out
);
  localparam logic [SEL_W-1:0] DSEL = SEL_W'(DEFAULT_SEL);

  logic [SEL_W-1:0]          sel_pend;
  logic                      pd_active;
  logic [NUM_OUT-1:0]        en_req_v, prd_end_v, en_act_v, armed_v;
  logic [NUM_OUT*CODE_W-1:0] code_act_v;

  assign pd_active = ~mode_oe & ~ctl_pin;

  sel_sync #(.W(SEL_W), .RST_VAL(DSEL)) u_sync (
    .clk(clk_src), .rst_n(rst_n), .d(fsel), .q(sel_pend)
  );

  for (genvar c = 0; c < NUM_OUT; c++) begin : g_ch
    localparam code_t DCODE = SEL_TBL[(DEFAULT_SEL*NUM_OUT + c)*CODE_W +: CODE_W];
    code_t pend_code;

    assign pend_code   = SEL_TBL[(int'(sel_pend)*NUM_OUT + c)*CODE_W +: CODE_W];
    assign en_req_v[c] = mode_oe ? (ctl_pin | ~oe_mask[c]) : 1'b1;

    div_channel #(.DFLT_CODE(DCODE)) u_ch (
      .clk      (clk_src),
      .rst_n    (rst_n),
      .pd       (pd_active),
      .pend_code(pend_code),
      .en_req   (en_req_v[c]),
      .clk_o    (clk_out[c]),
      .prd_end  (prd_end_v[c]),
      .code_act (code_act_v[c*CODE_W +: CODE_W]),
      .en_act   (en_act_v[c]),
      .armed    (armed_v[c])
    );
  end
endmodule

// File: rtl/glitchless_div_bank_chk.sv
module glitchless_div_bank_chk #(
  parameter int NUM_OUT = 3,
  parameter int CODE_W  = 8
) (
  input logic                      clk_src,
  input logic                      rst_n,
  input logic                      pd_active,
  input logic [NUM_OUT-1:0]        prd_end_v,
  input logic [NUM_OUT-1:0]        en_act_v,
  input logic [NUM_OUT-1:0]        armed_v,
  input logic [NUM_OUT*CODE_W-1:0] code_act_v,
  input logic [NUM_OUT-1:0]        clk_out
);
  a_r8_pd_low: assert property (@(posedge clk_src) disable iff (!rst_n)
    pd_active |=> (clk_out == '0));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_a
    a_r10_low_at_end: assert property (@(posedge clk_src) disable iff (!rst_n)
      prd_end_v[i] |-> !clk_out[i]);

    a_r4_code_at_boundary: assert property (@(posedge clk_src) disable iff (!rst_n)
      (!pd_active && !prd_end_v[i]) |=> $stable(code_act_v[i*CODE_W +: CODE_W]));

    a_r7_en_at_boundary: assert property (@(posedge clk_src) disable iff (!rst_n)
      (!pd_active && armed_v[i] && !prd_end_v[i]) |=> $stable(en_act_v[i]));

    a_r5_rise_at_start: assert property (@(posedge clk_src) disable iff (!rst_n)
      $rose(clk_out[i]) |-> $past(prd_end_v[i] || !armed_v[i]));
  end
endmodule

bind glitchless_div_bank glitchless_div_bank_chk #(.NUM_OUT(NUM_OUT), .CODE_W(clkdiv_pkg::CODE_W)) u_chk (
  .clk_src   (clk_src),
  .rst_n     (rst_n),
  .pd_active (pd_active),
  .prd_end_v (prd_end_v),
  .en_act_v  (en_act_v),
  .armed_v   (armed_v),
  .code_act_v(code_act_v),
  .clk_out   (clk_out)
);

// File: tb/glitchless_div_bank_bench.sv
module glitchless_div_bank_bench;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   fsel = 3'd0;
  logic         ctl = 1'b1;
  logic         mode_oe = 1'b0;
  logic [N-1:0] mask = '0;
  logic [N-1:0] clk_out;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  glitchless_div_bank u_glitchless_div_bank (
    .clk_src(clk), .rst_n(rst_n), .fsel(fsel), .ctl_pin(ctl),
    .mode_oe(mode_oe), .oe_mask(mask), .clk_out(clk_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ratio for select s, output c (code 0 entry counts as 2)
  function automatic int ratio(input int s, input int c);
    int r0[8] = '{2, 3, 4, 5, 8, 256, 7, 6};
    int r1[8] = '{4, 2, 9, 16, 3, 6, 10, 2};
    int r2[8] = '{6, 5, 2, 3, 12, 4, 100, 11};
    return (c == 0) ? r0[s] : (c == 1) ? r1[s] : r2[s];
  endfunction

  function automatic int hi_of(input int r); return (r + 1) / 2; endfunction
  function automatic int lo_of(input int r); return r / 2; endfunction

  task automatic sync_rise(input int c);
    int g = 0;
    while (clk_out[c] !== 1'b0 && g < 1000) begin @(negedge clk); g++; end
    while (clk_out[c] !== 1'b1 && g < 1000) begin @(negedge clk); g++; end
  endtask

  task automatic meas(input int c, output int hi, output int lo);
    hi = 0; lo = 0;
    while (clk_out[c] === 1'b1 && hi < 1000) begin hi++; @(negedge clk); end
    while (clk_out[c] === 1'b0 && lo < 1000) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(clk_out == '0, "R1", int'(clk_out), 0, "outputs during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(clk_out == '1, "R1", int'(clk_out), 7, "outputs high after first edge");
  endtask

  task automatic t_ratios();
    int sels[4] = '{0, 3, 6, 7};
    int hi, lo;
    for (int k = 0; k < 4; k++) begin
      fsel = 3'(sels[k]);
      repeat (300) @(negedge clk);
      for (int c = 0; c < N; c++) begin
        int r = ratio(sels[k], c);
        sync_rise(c);
        meas(c, hi, lo);
        check(hi == hi_of(r), "R3", hi, hi_of(r), "high phase");
        check(lo == lo_of(r), "R3", lo, lo_of(r), "low phase");
        check(lo >= 1, "R10", lo, 1, "period ends low");
      end
    end
    // R2: select 7 output 1 holds code 0, treated as ratio 2
    check(ratio(7, 1) == 2, "R2", ratio(7, 1), 2, "clamp table");
  endtask

  task automatic t_switch();
    int hi, lo;
    fsel = 3'd3;
    repeat (300) @(negedge clk);
    sync_rise(0);
    fsel = 3'd5;
    meas(0, hi, lo);
    check(hi == 3 && lo == 2, "R4", hi * 1000 + lo, 3002, "current period old ratio");
    meas(0, hi, lo);
    check(hi == 128 && lo == 128, "R4", hi * 1000 + lo, 128128, "next period new ratio");
    // mid-high-phase change on output 1: ratio 6 -> 3
    sync_rise(1);
    @(negedge clk);
    fsel = 3'd4;
    meas(1, hi, lo);
    check(hi == 2, "R5", hi, 2, "remaining high not shortened");
    check(lo == 3, "R5", lo, 3, "old low phase complete");
    meas(1, hi, lo);
    check(hi == 2 && lo == 1, "R5", hi * 1000 + lo, 2001, "new ratio after boundary");
  endtask

  task automatic t_oe();
    int hi, lo, ones;
    mode_oe = 1'b1; mask = 3'b010; ctl = 1'b1; fsel = 3'd2;
    repeat (60) @(negedge clk);
    sync_rise(1);
    ctl = 1'b0;
    hi = 0;
    while (clk_out[1] === 1'b1 && hi < 1000) begin hi++; @(negedge clk); end
    check(hi == 5, "R7", hi, 5, "high phase finishes after disable");
    ones = 0;
    for (int i = 0; i < 40; i++) begin
      if (clk_out[1]) ones++;
      @(negedge clk);
    end
    check(ones == 0, "R6", ones, 0, "masked output held low");
    sync_rise(0);
    meas(0, hi, lo);
    check(hi == 2 && lo == 2, "R6", hi * 1000 + lo, 2002, "unmasked output ignores pin");
    ctl = 1'b1;
    sync_rise(1);
    meas(1, hi, lo);
    check(hi == 5 && lo == 4, "R7", hi * 1000 + lo, 5004, "full first period after enable");
  endtask

  task automatic t_pd();
    int hi, lo, ones;
    mode_oe = 1'b0; mask = 3'b000; ctl = 1'b1; fsel = 3'd0;
    repeat (60) @(negedge clk);
    ctl = 1'b0;
    @(negedge clk);
    check(clk_out == '0, "R8", int'(clk_out), 0, "outputs low one edge after power-down");
    fsel = 3'd3;
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      if (clk_out != '0) ones++;
      @(negedge clk);
    end
    check(ones == 0, "R8", ones, 0, "outputs stay low in power-down");
    ctl = 1'b1;
    sync_rise(2);
    meas(2, hi, lo);
    check(hi == 3 && lo == 3, "R9", hi * 1000 + lo, 3003, "first period uses default");
    meas(2, hi, lo);
    check(hi == 2 && lo == 1, "R9", hi * 1000 + lo, 2001, "pending select applied next");
  endtask

  initial begin
    #(4 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ratios();
    t_switch();
    t_oe();
    t_pd();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule